// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs single machine cycles on an external bus whose low address byte and data byte share one set of lines. A client hands it a cycle kind (opcode fetch, memory read, memory write, I/O read, I/O write) and a 16-bit address. The block steps through clock states T1, T2, optional waits, T3 and, for fetches, T4, and it drives the upper address lines, the shared lines with their output enable, an address strobe, active-low read and write strobes, a memory/I/O select and a two-bit status code. It ends each cycle with a one-cycle done pulse and, for read-type cycles, the byte it captured.

A slow target stretches the cycle by holding the ready input low. Another bus master can ask for the bus with a hold request. The block grants it only between cycles, and while it is granted the block keeps all its strobes inactive and stops driving the shared lines.

The shared lines come out as three ports: an output byte, an output enable and an input byte. A pad ring or a tristate wrapper joins them into the bidirectional bus.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, the first cycle after a request is accepted, `ale` is high for exactly one clock. `addrHi` shows `reqAddr[15:8]`, `adOut` shows `reqAddr[7:0]` and `adOe` is 1. `addrHi` holds its value until the cycle ends.
- R2: `busStat` is 2'b11 for a fetch, 2'b10 for a memory or I/O read and 2'b01 for a memory or I/O write, for every T-state of the cycle. In idle and hold it is 2'b00.
- R3: `ioSel` is 1 during I/O read and I/O write cycles. It is 0 during memory cycles, in idle and in hold.
- R4: In a read-type cycle, `rdN` is 0 and `adOe` is 0 from T2 through T3, including any wait states. The byte on `adIn` at the clock edge that ends T3 is returned on `rdByte` while `done` is high.
- R5: In a write cycle, `wrN` is 0, `adOe` is 1 and `adOut` equals `reqWrData` from T2 through T3. `rdN` stays 1.
- R6: A fetch lasts 4 T-states plus any waits, and `rdN` is 1 in T4. The other kinds last 3 T-states plus any waits. `done` is high for one clock, in the cycle right after the last T-state.
- R7: `ready` is sampled at the end of T2 and at the end of each wait state. Every low sample adds one wait state, and the strobes keep their T2 values through it.
- R8: When `holdReq` is high at the end of a cycle's last T-state, or in idle, `holdAck` goes high in the next clock. While `holdAck` is high, `adOe` and `ale` are 0 and `rdN` and `wrN` are 1. In idle, a hold request wins over a bus request in the same clock. `holdAck` never goes high in the middle of a cycle. Dropping `holdReq` returns the block to idle in the next clock.
- R9: After reset, and in idle, `ale` is 0, `rdN` and `wrN` are 1, `adOe` is 0, `holdAck` is 0, `done` is 0 and `busy` is 0.
- R10: A request is taken only when `busy` is 0 and `reqKind` is one of 0 (fetch), 1 (memory read), 2 (memory write), 3 (I/O read) or 4 (I/O write). A request that arrives while busy, or in hold, or that carries a kind code of 5 to 7 starts no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a cycle (taken when not busy) |
| reqKind | input | 3 | Cycle kind code |
| reqAddr | input | 16 | Cycle address |
| reqWrData | input | 8 | Byte for write cycles |
| busy | output | 1 | Cycle or hold in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdByte | output | 8 | Byte captured by the last read-type cycle |
| addrHi | output | 8 | Upper address lines |
| adOut | output | 8 | Shared lines, driven value |
| adOe | output | 1 | Shared lines output enable |
| adIn | input | 8 | Shared lines, received value |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioSel | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| busStat | output | 2 | Cycle status code |
| ready | input | 1 | Target ready; low adds wait states |
| holdReq | input | 1 | Bus request from another master |
| holdAck | output | 1 | Bus granted to the other master |

## Verification
The bench builds the block with its default 16-bit address and 8-bit data widths. With these widths the upper address lines are a full byte, so every address bit can be seen on some port. The vector table covers all five cycle kinds with 0 to 3 wait states. The bench drives the true byte on `adIn` only in the T3 clock, which shows whether the capture happens at the right edge even when waits stretch the cycle. Directed tests cover hold in idle, hold raised in the middle of a cycle, requests that collide with hold, and kind codes that are not defined.

// File: rtl/mux_bus_seq_pkg.sv
package mux_bus_seq_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_MEMRD = 3'd1,
    KIND_MEMWR = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4
  } cycKind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } seqState_e;

  localparam logic [1:0] STAT_HALT  = 2'b00;
  localparam logic [1:0] STAT_WRITE = 2'b01;
  localparam logic [1:0] STAT_READ  = 2'b10;
  localparam logic [1:0] STAT_FETCH = 2'b11;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadReq;    // register address and write byte
    logic captureRd;  // sample the shared lines
    logic addrPhase;  // shared lines carry the low address
    logic inCycle;    // a T-state is in progress
  } seqStrobe_t;

endpackage

// File: rtl/mux_bus_seq_dp.sv
module mux_bus_seq_dp
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  output logic [DATA_W-1:0] rdByte
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
    end else if (strobes.loadReq) begin
      addrQ   <= reqAddr;
      wrDataQ <= reqWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (strobes.captureRd) begin
      rdDataQ <= adIn;
    end
  end

  assign addrHi = addrQ[ADDR_W-1 -: HI_W];
  assign adOut  = strobes.addrPhase ? addrQ[DATA_W-1:0] : wrDataQ;
  assign rdByte = rdDataQ;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.inCycle && $past(strobes.inCycle)) |-> $stable(addrHi)); // R1

endmodule

// File: rtl/mux_bus_seq_ctl.sv
module mux_bus_seq_ctl
  import mux_bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       ready,
  input  logic       holdReq,
  output seqStrobe_t strobes,
  output logic       ale,
  output logic       rdN,
  output logic       wrN,
  output logic       adOe,
  output logic [1:0] busStat,
  output logic       ioSel,
  output logic       holdAck,
  output logic       done,
  output logic       busy
);

  seqState_e stateQ, stateD;
  cycKind_e  kindQ;
  logic      doneQ;
  logic      kindOk;
  logic      startCyc;
  logic      lastT;
  logic      isRead, isWrite, isIo, isFetch;
  logic      dataPhase, inBus;

  assign kindOk   = (reqKind <= 3'd4);
  assign startCyc = (stateQ == ST_IDLE) && !holdReq && reqValid && kindOk;

  assign isFetch = (kindQ == KIND_FETCH);
  assign isRead  = (kindQ == KIND_FETCH) || (kindQ == KIND_MEMRD) || (kindQ == KIND_IORD);
  assign isWrite = (kindQ == KIND_MEMWR) || (kindQ == KIND_IOWR);
  assign isIo    = (kindQ == KIND_IORD) || (kindQ == KIND_IOWR);

  assign lastT = (stateQ == ST_T4) || ((stateQ == ST_T3) && !isFetch);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (holdReq)       stateD = ST_HOLD;
        else if (startCyc) stateD = ST_T1;
      end
      ST_T1:   stateD = ST_T2;
      ST_T2, ST_TW: stateD = ready ? ST_T3 : ST_TW;
      ST_T3:   stateD = isFetch ? ST_T4 : (holdReq ? ST_HOLD : ST_IDLE);
      ST_T4:   stateD = holdReq ? ST_HOLD : ST_IDLE;
      ST_HOLD: stateD = holdReq ? ST_HOLD : ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      kindQ  <= KIND_FETCH;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= lastT;
      if (startCyc) kindQ <= cycKind_e'(reqKind);
    end
  end

  assign dataPhase = (stateQ == ST_T2) || (stateQ == ST_TW) || (stateQ == ST_T3);
  assign inBus     = (stateQ == ST_T1) || dataPhase || (stateQ == ST_T4);

  always_comb begin
    strobes           = '0;
    strobes.loadReq   = startCyc;
    strobes.captureRd = (stateQ == ST_T3) && isRead;
    strobes.addrPhase = (stateQ == ST_T1);
    strobes.inCycle   = inBus;
  end

  always_comb begin
    busStat = STAT_HALT;
    if (inBus) begin
      if (isFetch)      busStat = STAT_FETCH;
      else if (isRead)  busStat = STAT_READ;
      else              busStat = STAT_WRITE;
    end
  end

  assign ale     = (stateQ == ST_T1);
  assign rdN     = !(dataPhase && isRead);
  assign wrN     = !(dataPhase && isWrite);
  assign adOe    = (stateQ == ST_T1) || (dataPhase && isWrite);
  assign ioSel   = inBus && isIo;
  assign holdAck = (stateQ == ST_HOLD);
  assign done    = doneQ;
  assign busy    = (stateQ != ST_IDLE);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R5
  AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R1
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && adOe)); // R1
  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R4
  AST_STAT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> $stable(busStat)); // R2
  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!adOe && !ale && rdN && wrN && busStat == STAT_HALT)); // R8
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> (done || $past(!busy))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [2:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdByte,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioSel,
  output logic [1:0]               busStat,
  input  logic                     ready,
  input  logic                     holdReq,
  output logic                     holdAck
);

  seqStrobe_t strobes;

  mux_bus_seq_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .ready    (ready),
    .holdReq  (holdReq),
    .strobes  (strobes),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .adOe     (adOe),
    .busStat  (busStat),
    .ioSel    (ioSel),
    .holdAck  (holdAck),
    .done     (done),
    .busy     (busy)
  );

  mux_bus_seq_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .adIn      (adIn),
    .addrHi    (addrHi),
    .adOut     (adOut),
    .rdByte    (rdByte)
  );

endmodule

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWrData = 8'h0;
  logic        busy, done, adOe, ale, rdN, wrN, ioSel, holdAck;
  logic [7:0]  rdByte, addrHi, adOut;
  logic [7:0]  adIn = 8'h0;
  logic [1:0]  busStat;
  logic        ready = 1'b1;
  logic        holdReq = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  mux_bus_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busy(busy), .done(done),
    .rdByte(rdByte), .addrHi(addrHi), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .ale(ale), .rdN(rdN), .wrN(wrN), .ioSel(ioSel),
    .busStat(busStat), .ready(ready), .holdReq(holdReq), .holdAck(holdAck)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // {kind[2:0], addr[15:0], wrData[7:0], readByte[7:0], waits[2:0]}
  localparam int NVEC = 9;
  localparam logic [37:0] VECS [NVEC] = '{
    {3'd0, 16'h2005, 8'h00, 8'h4F, 3'd0},
    {3'd1, 16'h2001, 8'h00, 8'h32, 3'd0},
    {3'd2, 16'h2065, 8'hA7, 8'h00, 3'd0},
    {3'd3, 16'h0002, 8'h00, 8'h5C, 3'd1},
    {3'd4, 16'h00F3, 8'h3C, 8'h00, 3'd2},
    {3'd0, 16'hFFFF, 8'h00, 8'hC3, 3'd3},
    {3'd1, 16'h8000, 8'h00, 8'h00, 3'd2},
    {3'd2, 16'h0000, 8'hFF, 8'h00, 3'd1},
    {3'd3, 16'h5AA5, 8'h00, 8'h81, 3'd0}
  };

  // Runs one cycle; holdAt >= 0 raises holdReq in that T-state index.
  task automatic runCycle(input logic [2:0] kind, input logic [15:0] addr,
                          input logic [7:0] wd, input logic [7:0] rb,
                          input int waits, input int holdAt);
    logic isRd, isWr, isIo, isF;
    logic [1:0] expStat;
    int nT;
    isF  = (kind == 3'd0);
    isRd = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3);
    isWr = (kind == 3'd2) || (kind == 3'd4);
    isIo = (kind == 3'd3) || (kind == 3'd4);
    expStat = isF ? 2'b11 : (isRd ? 2'b10 : 2'b01);
    nT = (isF ? 4 : 3) + waits;
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqWrData = wd;
    ready = 1'b0; adIn = ~rb;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = ~addr; reqWrData = ~wd;
    for (int i = 0; i <= nT + 1; i++) begin
      if (i == 0) begin
        chk(ale == 1'b1, "R1 ale in T1", ale, 1);
        chk(addrHi == addr[15:8], "R1 high address", addrHi, addr[15:8]);
        chk(adOut == addr[7:0], "R1 low address", adOut, addr[7:0]);
        chk(adOe == 1'b1, "R1 enable in T1", adOe, 1);
        chk(rdN && wrN, "R1 strobes idle in T1", {rdN, wrN}, 3);
      end else if (i < nT) begin
        chk(ale == 1'b0, "R1 ale low after T1", ale, 0);
        chk(addrHi == addr[15:8], "R1 high address held", addrHi, addr[15:8]);
      end
      if (i < nT) begin
        chk(busStat == expStat, "R2 status", busStat, expStat);
        chk(ioSel == isIo, "R3 io select", ioSel, isIo);
        chk(done == 1'b0, "R6 no early done", done, 0);
        chk(busy == 1'b1, "R10 busy in cycle", busy, 1);
      end
      if (i >= 1 && i <= 2 + waits) begin
        chk(rdN == !isRd, "R4 read strobe", rdN, !isRd);
        chk(wrN == !isWr, "R5 write strobe", wrN, !isWr);
        chk(adOe == isWr, "R4 R5 enable in data phase", adOe, isWr);
        if (isWr) chk(adOut == wd, "R5 write data", adOut, wd);
      end
      if (isF && i == nT - 1) begin
        chk(rdN == 1'b1 && adOe == 1'b0, "R6 T4 quiet", {rdN, adOe}, 2);
      end
      if (i == nT) begin
        chk(done == 1'b1, "R6 done after last T-state", done, 1);
        if (isRd) chk(rdByte == rb, "R4 captured byte", rdByte, rb);
        chk(busStat == 2'b00, "R2 halt status after cycle", busStat, 0);
        chk(holdAck == (holdAt >= 0), "R8 grant at cycle end", holdAck, holdAt >= 0);
      end
      if (i == nT + 1) begin
        chk(done == 1'b0, "R6 done one clock", done, 0);
      end
      if (i < nT && holdAt >= 0) begin
        chk(holdAck == 1'b0, "R8 no grant mid-cycle", holdAck, 0);
      end
      // R7: ready low for 'waits' samples starting at T2
      ready = (i >= 1 + waits);
      adIn = (i == nT - 1 - (isF ? 1 : 0)) ? rb : ~rb;
      if (holdAt >= 0 && i == holdAt) holdReq = 1'b1;
      @(negedge clk);
    end
    ready = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(ale == 1'b0 && rdN && wrN, "R9 strobes in reset", {ale, rdN, wrN}, 3);
    chk(adOe == 1'b0 && holdAck == 1'b0, "R9 enable and grant in reset", {adOe, holdAck}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 idle after reset", {busy, done}, 0);
    chk(busStat == 2'b00 && ioSel == 1'b0, "R2 R3 idle status", {busStat, ioSel}, 0);

    for (int v = 0; v < NVEC; v++) begin
      runCycle(VECS[v][37:35], VECS[v][34:19], VECS[v][18:11], VECS[v][10:3],
               int'(VECS[v][2:0]), -1);
    end

    // R8: hold raised in T2 of a read with one wait; granted only at end
    runCycle(3'd1, 16'h1234, 8'h00, 8'h9E, 1, 1);
    chk(holdAck == 1'b1 && adOe == 1'b0, "R8 hold kept", {holdAck, adOe}, 2);
    // R10: request during hold starts nothing
    reqValid = 1'b1; reqKind = 3'd2; reqAddr = 16'hBEEF;
    @(negedge clk);
    reqValid = 1'b0;
    chk(ale == 1'b0 && wrN == 1'b1, "R10 request ignored in hold", {ale, wrN}, 1);
    holdReq = 1'b0;
    @(negedge clk);
    chk(holdAck == 1'b0 && busy == 1'b0, "R8 release to idle", {holdAck, busy}, 0);
    @(negedge clk);
    chk(ale == 1'b0 && busy == 1'b0, "R10 request not remembered", {ale, busy}, 0);

    // R8: hold and request together in idle, hold wins
    holdReq = 1'b1; reqValid = 1'b1; reqKind = 3'd1; reqAddr = 16'h4455;
    @(negedge clk);
    reqValid = 1'b0;
    chk(holdAck == 1'b1 && ale == 1'b0, "R8 hold beats request", {holdAck, ale}, 2);
    chk(rdN && wrN && !adOe, "R8 bus released", {rdN, wrN, adOe}, 6);
    holdReq = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && ale == 1'b0, "R8 idle after hold", {busy, ale}, 0);

    // R10: undefined kind codes start nothing
    for (int k = 5; k < 8; k++) begin
      reqValid = 1'b1; reqKind = 3'(k); reqAddr = 16'h7777;
      @(negedge clk);
      reqValid = 1'b0;
      chk(busy == 1'b0 && ale == 1'b0, "R10 bad kind ignored", {busy, ale}, 0);
    end

    // R10: request while busy is dropped
    reqValid = 1'b1; reqKind = 3'd1; reqAddr = 16'h0101;
    @(negedge clk);
    reqKind = 3'd2; reqAddr = 16'h0202;
    @(negedge clk);
    reqValid = 1'b0;
    chk(addrHi == 8'h01 && rdN == 1'b0, "R10 busy request dropped", {addrHi, rdN}, 16'h0100);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 single cycle only", busy, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule